// File: doc/BRIEF.md
# Hardwired Bus-Select Control Sequencer

This block is the hardwired control unit of a small accumulator datapath in which every element hangs off one shared bus. Each element has a numeric bus address. The sequencer names one source on a three-bit read-select group and one destination on a three-bit write-select group. A one-hot timing ring counter walks through the steps of an instruction. The operation code from the instruction register is decoded once. The control word for a step is the decoded instruction line ANDed with the active timing step.

Three instructions are decoded: load, add and subtract. Each one moves the address field of the instruction register to the memory address register. It then reads memory into the memory buffer register. Next it drives the buffer onto the bus toward the accumulator, with the ALU set to add, subtract or do nothing. A final step raises the counter-clear line, so the ring counter starts the next instruction at its first step. An opcode the decoder does not know raises the clear line straight away, so the instruction costs a single cycle.

Bus addresses are fixed: memory 0, memory address register 1, memory buffer register 3, accumulator 4, instruction register 7. A write select of 0 names a memory write.

Top module: `bus_seq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the timing counter at its first step (`t_step` = 8'h01) at the next clock edge, also in the middle of an instruction.
- R2: After reset, `t_step` has exactly one bit high. When `cnt_clr` is low at a clock edge, the high bit moves one place up, and bit 7 wraps to bit 0.
- R3: When `cnt_clr` is high at a clock edge, `t_step` becomes 8'h01.
- R4: With opcode 4'h3 (add), the four steps drive: step 0 `p_rd`=7 and `p_wr`=1; step 1 `p_rd`=0 and `p_wr`=3; step 2 `p_rd`=3, `p_wr`=4 and `alu_op`=4'b0001; step 3 `cnt_clr`=1.
- R5: With opcode 4'h1 (load), the steps are the same as for add, except that at step 2 `alu_op` = 4'b1000 (do nothing).
- R6: With opcode 4'h4 (subtract), the steps are the same as for add, except that at step 2 `alu_op` = 4'b0010.
- R7: Any opcode other than 4'h1, 4'h3 or 4'h4 raises `cnt_clr` in whatever step is current and drives `p_rd`=0 and `p_wr`=0. From step 0 the instruction therefore takes one cycle.
- R8: `alu_op` is always one-hot. Bit 0 is add, bit 1 subtract, bit 2 clear and bit 3 do nothing. Bit 2 is never raised. Bit 3 is high in every step other than step 2 of an add or a subtract.
- R9: Whenever `cnt_clr` is high, `p_rd` and `p_wr` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the timing counter |
| opcode | input | 4 | Operation code from the instruction register |
| p_rd | output | 3 | Bus address of the element read this step (P2..P0) |
| p_wr | output | 3 | Bus address of the element written this step (P5..P3) |
| alu_op | output | 4 | One-hot ALU select: add, subtract, clear, do nothing |
| t_step | output | 8 | One-hot timing step T0..T7 |
| cnt_clr | output | 1 | Counter clear: the next step is T0 |

## Verification
The per-step properties assume that `opcode` is held steady while an instruction runs, because the control word is decoded from it again in every step. The one exception is a deliberate switch to an undecoded value, which aborts the instruction. The vector walk drives each instruction's opcode through all of its steps in order. The single directed test that changes the opcode mid-instruction does so only to provoke the clear path. The one-hot and advance properties rely on reset having been applied once before they are enabled, and the stimulus always opens with reset.

// File: rtl/cu_pkg.sv
package cu_pkg;
  localparam int OPC_W = 4;
  localparam int BUS_W = 3;
  localparam int ALU_W = 4;

  // bus addresses of datapath elements
  localparam logic [BUS_W-1:0] BA_MEM = 3'd0;
  localparam logic [BUS_W-1:0] BA_MAR = 3'd1;
  localparam logic [BUS_W-1:0] BA_MBR = 3'd3;
  localparam logic [BUS_W-1:0] BA_AC  = 3'd4;
  localparam logic [BUS_W-1:0] BA_IR  = 3'd7;

  // decoded operation codes
  localparam logic [OPC_W-1:0] OP_LOAD = 4'h1;
  localparam logic [OPC_W-1:0] OP_ADD  = 4'h3;
  localparam logic [OPC_W-1:0] OP_SUB  = 4'h4;

  // one-hot ALU lines
  localparam logic [ALU_W-1:0] ALU_ADD = 4'b0001;
  localparam logic [ALU_W-1:0] ALU_SUB = 4'b0010;
  localparam logic [ALU_W-1:0] ALU_CLR = 4'b0100;
  localparam logic [ALU_W-1:0] ALU_NOP = 4'b1000;

  // step positions of the memory-operand instruction pattern
  localparam int STEP_ADDR  = 0;
  localparam int STEP_FETCH = 1;
  localparam int STEP_EXEC  = 2;
  localparam int STEP_DONE  = 3;

  typedef struct packed {
    logic is_load;
    logic is_add;
    logic is_sub;
    logic is_bad;
  } dec_t;
endpackage

// File: rtl/cu_ring_timer.sv
module cu_ring_timer #(
  parameter int NSTEPS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  output logic [NSTEPS-1:0] t_q
);
  localparam logic [NSTEPS-1:0] FIRST = {{(NSTEPS-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clr) t_q <= FIRST;
    else            t_q <= {t_q[NSTEPS-2:0], t_q[NSTEPS-1]};
  end

  assert_ring_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(t_q));
endmodule

// File: rtl/cu_op_decode.sv
module cu_op_decode import cu_pkg::*; (
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);
  always_comb begin
    dec.is_load = (opcode == OP_LOAD);
    dec.is_add  = (opcode == OP_ADD);
    dec.is_sub  = (opcode == OP_SUB);
    dec.is_bad  = !(dec.is_load || dec.is_add || dec.is_sub);
  end
endmodule

// File: rtl/cu_signal_matrix.sv
module cu_signal_matrix import cu_pkg::*; #(
  parameter int NSTEPS = 8
) (
  input  dec_t              dec,
  input  logic [NSTEPS-1:0] t_step,
  output logic [BUS_W-1:0]  p_rd,
  output logic [BUS_W-1:0]  p_wr,
  output logic [ALU_W-1:0]  alu_op,
  output logic              cnt_clr
);
  logic late;

  // steps past the last used one fall back to a clear
  generate
    if (NSTEPS > STEP_DONE + 1) begin : g_late
      assign late = |t_step[NSTEPS-1:STEP_DONE+1];
    end else begin : g_nolate
      assign late = 1'b0;
    end
  endgenerate

  always_comb begin
    p_rd    = '0;
    p_wr    = '0;
    alu_op  = ALU_NOP;
    cnt_clr = 1'b0;
    if (dec.is_bad || late) begin
      cnt_clr = 1'b1;
    end else if (t_step[STEP_ADDR]) begin
      p_rd = BA_IR;
      p_wr = BA_MAR;
    end else if (t_step[STEP_FETCH]) begin
      p_rd = BA_MEM;
      p_wr = BA_MBR;
    end else if (t_step[STEP_EXEC] && (dec.is_load || dec.is_add || dec.is_sub)) begin
      p_rd = BA_MBR;
      p_wr = BA_AC;
      if (dec.is_add)      alu_op = ALU_ADD;
      else if (dec.is_sub) alu_op = ALU_SUB;
    end else if (t_step[STEP_DONE]) begin
      cnt_clr = 1'b1;
    end
  end
endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl import cu_pkg::*; #(
  parameter int NSTEPS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  output logic [BUS_W-1:0]  p_rd,
  output logic [BUS_W-1:0]  p_wr,
  output logic [ALU_W-1:0]  alu_op,
  output logic [NSTEPS-1:0] t_step,
  output logic              cnt_clr
);
  localparam logic [NSTEPS-1:0] FIRST = {{(NSTEPS-1){1'b0}}, 1'b1};

  dec_t dec;

  cu_ring_timer #(.NSTEPS(NSTEPS)) timer_i (
    .clk(clk), .rst(rst), .clr(cnt_clr), .t_q(t_step)
  );

  cu_op_decode decode_i (.opcode(opcode), .dec(dec));

  cu_signal_matrix #(.NSTEPS(NSTEPS)) matrix_i (
    .dec(dec), .t_step(t_step), .p_rd(p_rd), .p_wr(p_wr),
    .alu_op(alu_op), .cnt_clr(cnt_clr)
  );

  assert_reset_first_R1: assert property (@(posedge clk)
    rst |=> t_step == FIRST);

  assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr |=> t_step == {$past(t_step[NSTEPS-2:0]), $past(t_step[NSTEPS-1])});

  assert_clear_restart_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> t_step == FIRST);

  assert_add_exec_R4: assert property (@(posedge clk) disable iff (rst)
    (t_step[STEP_EXEC] && opcode == OP_ADD) |-> (alu_op == ALU_ADD && p_wr == BA_AC));

  assert_sub_exec_R6: assert property (@(posedge clk) disable iff (rst)
    (t_step[STEP_EXEC] && opcode == OP_SUB) |-> (alu_op == ALU_SUB && p_rd == BA_MBR));

  assert_bad_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (opcode != OP_LOAD && opcode != OP_ADD && opcode != OP_SUB) |-> cnt_clr);

  assert_alu_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot(alu_op) && !alu_op[2]);

  assert_clear_idle_bus_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |-> (p_rd == '0 && p_wr == '0));
endmodule

// File: tb/bus_seq_ctrl_tb.sv
module bus_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic [3:0] op;
    logic [2:0] t;
    logic [2:0] rd;
    logic [2:0] wr;
    logic [3:0] alu;
    logic       clr;
  } vec_t;

  // op, step, read, write, alu, clear
  localparam vec_t VEC [NV] = '{
    '{4'h3, 3'd0, 3'd7, 3'd1, 4'b1000, 1'b0},   // R4
    '{4'h3, 3'd1, 3'd0, 3'd3, 4'b1000, 1'b0},   // R4
    '{4'h3, 3'd2, 3'd3, 3'd4, 4'b0001, 1'b0},   // R4
    '{4'h3, 3'd3, 3'd0, 3'd0, 4'b1000, 1'b1},   // R4 R9
    '{4'h1, 3'd0, 3'd7, 3'd1, 4'b1000, 1'b0},   // R5
    '{4'h1, 3'd1, 3'd0, 3'd3, 4'b1000, 1'b0},   // R5
    '{4'h1, 3'd2, 3'd3, 3'd4, 4'b1000, 1'b0},   // R5
    '{4'h1, 3'd3, 3'd0, 3'd0, 4'b1000, 1'b1},   // R5
    '{4'h4, 3'd0, 3'd7, 3'd1, 4'b1000, 1'b0},   // R6
    '{4'h4, 3'd1, 3'd0, 3'd3, 4'b1000, 1'b0},   // R6
    '{4'h4, 3'd2, 3'd3, 3'd4, 4'b0010, 1'b0},   // R6
    '{4'h4, 3'd3, 3'd0, 3'd0, 4'b1000, 1'b1},   // R6
    '{4'h0, 3'd0, 3'd0, 3'd0, 4'b1000, 1'b1},   // R7
    '{4'h2, 3'd0, 3'd0, 3'd0, 4'b1000, 1'b1},   // R7
    '{4'hF, 3'd0, 3'd0, 3'd0, 4'b1000, 1'b1},   // R7
    '{4'h3, 3'd0, 3'd7, 3'd1, 4'b1000, 1'b0}    // R3 restart
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] opcode;
  logic [2:0] p_rd, p_wr;
  logic [3:0] alu_op;
  logic [7:0] t_step;
  logic       cnt_clr;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .p_rd(p_rd), .p_wr(p_wr),
    .alu_op(alu_op), .t_step(t_step), .cnt_clr(cnt_clr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] pack_out();
    return {t_step, p_rd, p_wr, alu_op, cnt_clr, 4'h0};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    opcode = 4'h3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(t_step == 8'h01, "R1 reset state", {24'h0, t_step}, 32'h01);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] exp_o;
      opcode = VEC[i].op;
      #1;
      exp_o = {8'h01 << VEC[i].t, VEC[i].rd, VEC[i].wr, VEC[i].alu, VEC[i].clr, 4'h0};
      check(pack_out() == exp_o, "R2 R4 R5 R6 R7 R9 vector",
            {9'h0, pack_out()}, {9'h0, exp_o});
      check($countones(alu_op) == 1 && !alu_op[2], "R8 alu one-hot",
            {28'h0, alu_op}, {28'h0, VEC[i].alu});
      @(negedge clk);
    end

    // R1: reset in the middle of an add (now at step 1, move to step 2)
    @(negedge clk);
    check(t_step == 8'h04, "R2 reached step 2", {24'h0, t_step}, 32'h04);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(t_step == 8'h01 && p_rd == 3'd7 && p_wr == 3'd1, "R1 mid-instruction reset",
          {21'h0, t_step, p_rd}, {21'h0, 8'h01, 3'd7});

    // R7: undecoded opcode at step 1 aborts, R3: restart at step 0
    @(negedge clk);
    opcode = 4'h2;
    #1;
    check(t_step == 8'h02 && cnt_clr && p_rd == 3'd0 && p_wr == 3'd0,
          "R7 abort at step 1", {20'h0, t_step, cnt_clr, p_rd},
          {20'h0, 8'h02, 1'b1, 3'd0});
    @(negedge clk);
    opcode = 4'h3;
    #1;
    check(t_step == 8'h01 && !cnt_clr, "R3 restart after clear",
          {23'h0, t_step, cnt_clr}, {23'h0, 8'h01, 1'b0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule